// File: doc/BRIEF.md
# Quadrature Input Noise Filter

This block cleans up the two raw quadrature lines of one motion axis before they reach the decoder and counter. Each line first passes through a synchronizer into the system clock domain. The block then samples it on a slow sample strobe. A programmable 8-bit divider sets how often that strobe fires. A line's filtered copy takes a new level only after the synchronized input has held that level on several back-to-back samples. Short spikes therefore never reach the counter.

The block also watches for activity faster than this filter can follow. Suppose a line leaves its filtered level and then returns before the stability run completes. The block then sets a shared noise flag. The flag holds until an explicit clear strobe. Each axis has its own instance, so the divider value and the flag of one axis are set independently of the other.

Top module: `quad_noise_filter`

## Requirements
- R1: While reset is asserted, both filtered outputs and the noise flag are 0. The first samples after reset compare against filtered level 0.
- R2: With divider value P on `prescale` (0 to 255), a sample is taken once every P+1 system clocks. If the value is lowered below the clocks already elapsed, a sample is taken on the next clock.
- R3: Each raw line passes through two synchronizer flops. Its filtered output changes to a new level on the third consecutive sample that shows that level. With P=0, a raw step driven before clock edge k appears on the output after edge k+4.
- R4: A raw level that is seen on fewer than three consecutive samples never reaches the filtered output.
- R5: The noise flag sets on a sample where a line's synchronized input equals its filtered level again, after it differed on one or two preceding samples.
- R6: The noise flag is sticky. It holds through any number of quiet clocks. An `err_clr` high at a clock edge clears it at that edge, unless a new glitch is detected at the same edge, in which case the flag stays 1.
- R7: The two lines are filtered independently. Activity on line A never changes `filt_b`, and activity on line B never changes `filt_a`. The noise flag is the OR of both lines' glitch events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_a | input | 1 | Unfiltered quadrature line A |
| raw_b | input | 1 | Unfiltered quadrature line B |
| prescale | input | 8 | Sample divider value P; sample period is P+1 clocks |
| err_clr | input | 1 | Clears the noise flag at the clock edge where it is high |
| filt_a | output | 1 | Filtered line A |
| filt_b | output | 1 | Filtered line B |
| noise_err | output | 1 | Sticky noise flag |

## Verification
Any fault in the divider count, the run counter or the synchronizer changes when `filt_a` or `filt_b` flips. This shows up as an edge one or more sample periods early or late, on the next level change of the line. Under random stimulus that fault surfaces within a few hundred clocks. A run counter that is not reset on a returning level lets a spike through to the filtered output. It also leaves the noise flag unset on that same sample edge. A fault in the flag register shows at the first clear strobe or the first glitch afterwards, because the flag is compared on every clock against a cycle-level model.

// File: rtl/qgf_pkg.sv
`timescale 1ns/1ps
package qgf_pkg;

   // Per-line filter result: registered level plus a one-cycle glitch event
   typedef struct packed {
      logic level;
      logic glitch;
   } qgf_ch_out_t;

   // Width of a counter that holds 0 .. n-1
   function automatic int unsigned qgf_run_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/qgf_prescaler.sv
`timescale 1ns/1ps
module qgf_prescaler #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div,
   output logic         tick
);

   logic [W-1:0] cnt_q;

   // ">=" rather than "==" so that lowering div mid-period fires at once
   assign tick = (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/qgf_sync.sv
`timescale 1ns/1ps
module qgf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 1) begin : g_single
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= d;
         end
         assign q = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/qgf_channel.sv
`timescale 1ns/1ps
module qgf_channel import qgf_pkg::*; #(
   parameter int unsigned STABLE = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        din,
   output qgf_ch_out_t o
);

   localparam int unsigned RW = qgf_run_width(STABLE);
   localparam logic [RW-1:0] RUN_LAST = RW'(STABLE - 1);

   logic          level_q, level_d;
   logic [RW-1:0] run_q, run_d;
   logic          glitch;

   always_comb begin
      level_d = level_q;
      run_d   = run_q;
      glitch  = 1'b0;
      if (tick) begin
         if (din != level_q) begin
            if (run_q == RUN_LAST) begin
               level_d = din;
               run_d   = '0;
            end else begin
               run_d = run_q + RW'(1);
            end
         end else if (run_q != '0) begin
            // level came back before the run finished
            glitch = 1'b1;
            run_d  = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         run_q   <= '0;
      end else begin
         level_q <= level_d;
         run_q   <= run_d;
      end
   end

   assign o.level  = level_q;
   assign o.glitch = glitch;

endmodule

// File: rtl/quad_noise_filter.sv
`timescale 1ns/1ps
module quad_noise_filter import qgf_pkg::*; #(
   parameter int unsigned PRESCALE_W    = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned STABLE_COUNT  = 3,
   parameter bit          FLAG_SET_WINS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  raw_a,
   input  logic                  raw_b,
   input  logic [PRESCALE_W-1:0] prescale,
   input  logic                  err_clr,
   output logic                  filt_a,
   output logic                  filt_b,
   output logic                  noise_err
);

   localparam int unsigned NUM_CH = 2;

   generate
      if (PRESCALE_W < 1 || PRESCALE_W > 16) begin : g_bad_pw
         $error("PRESCALE_W must be within 1..16");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 1..4");
      end
      if (STABLE_COUNT < 1 || STABLE_COUNT > 16) begin : g_bad_stable
         $error("STABLE_COUNT must be within 1..16");
      end
   endgenerate

   logic              smp_tick;
   logic [NUM_CH-1:0] raw_vec;
   logic [NUM_CH-1:0] sync_lvl;
   logic [NUM_CH-1:0] ch_level;
   logic [NUM_CH-1:0] ch_glitch;
   logic              err_q;

   assign raw_vec = {raw_b, raw_a};

   qgf_prescaler #(.W(PRESCALE_W)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (prescale),
      .tick (smp_tick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      qgf_ch_out_t st;

      qgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (raw_vec[c]),
         .q    (sync_lvl[c])
      );

      qgf_channel #(.STABLE(STABLE_COUNT)) u_flt (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (smp_tick),
         .din  (sync_lvl[c]),
         .o    (st)
      );

      assign ch_level[c]  = st.level;
      assign ch_glitch[c] = st.glitch;
   end

   generate
      if (FLAG_SET_WINS) begin : g_flag_set
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          err_q <= 1'b0;
            else if (|ch_glitch) err_q <= 1'b1;
            else if (err_clr)    err_q <= 1'b0;
         end
      end else begin : g_flag_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          err_q <= 1'b0;
            else if (err_clr)    err_q <= 1'b0;
            else if (|ch_glitch) err_q <= 1'b1;
         end
      end
   endgenerate

   assign filt_a    = ch_level[0];
   assign filt_b    = ch_level[1];
   assign noise_err = err_q;

endmodule

// File: rtl/qgf_checker.sv
`timescale 1ns/1ps
module qgf_checker #(
   parameter int unsigned PW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [PW-1:0] prescale,
   input logic          err_clr,
   input logic          tick,
   input logic [1:0]    sync_lvl,
   input logic          glitch_any,
   input logic          filt_a,
   input logic          filt_b,
   input logic          noise_err
);

   logic seen_rst;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_rst <= 1'b1;
   end

   p_reset_outputs_r1: assert property (@(posedge clk)
      (!rst_n && seen_rst === 1'b1) |-> (!filt_a && !filt_b && !noise_err));

   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && prescale != '0) ##1 (prescale != '0) |-> !tick);

   p_filt_a_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_a != $past(filt_a)) |-> ($past(tick) && filt_a == $past(sync_lvl[0])));

   p_filt_b_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_b != $past(filt_b)) |-> ($past(tick) && filt_b == $past(sync_lvl[1])));

   p_glitch_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      glitch_any |-> tick);

   p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(noise_err) |-> $past(glitch_any));

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_err && !err_clr) |=> noise_err);

   p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !glitch_any) |=> !noise_err);

endmodule

bind quad_noise_filter qgf_checker #(.PW(PRESCALE_W)) u_qgf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .prescale  (prescale),
   .err_clr   (err_clr),
   .tick      (smp_tick),
   .sync_lvl  (sync_lvl),
   .glitch_any(|ch_glitch),
   .filt_a    (filt_a),
   .filt_b    (filt_b),
   .noise_err (noise_err)
);

// File: tb/quad_noise_filter_bench.sv
`timescale 1ns/1ps
module quad_noise_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       raw_a, raw_b, err_clr;
   logic [7:0] prescale;
   logic       filt_a, filt_b, noise_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit model_cmp = 0;

   always #10 clk = ~clk;

   quad_noise_filter u_quad_noise_filter (
      .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
      .prescale(prescale), .err_clr(err_clr),
      .filt_a(filt_a), .filt_b(filt_b), .noise_err(noise_err)
   );

   // Cycle model built from the requirements
   int   m_pc;
   logic m_s0 [2];
   logic m_s1 [2];
   logic m_filt [2];
   int   m_run [2];
   logic m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_err = 0;
         for (int c = 0; c < 2; c++) begin
            m_s0[c] = 0; m_s1[c] = 0; m_filt[c] = 0; m_run[c] = 0;
         end
      end else begin
         logic tk, g;
         logic rv [2];
         rv[0] = raw_a; rv[1] = raw_b;
         tk = (m_pc >= int'(prescale));                 // R2 sample period
         m_pc = tk ? 0 : m_pc + 1;
         g = 0;
         for (int c = 0; c < 2; c++) begin
            if (tk) begin
               if (m_s1[c] != m_filt[c]) begin
                  if (m_run[c] == 2) begin m_filt[c] = m_s1[c]; m_run[c] = 0; end   // R3
                  else m_run[c] = m_run[c] + 1;
               end else if (m_run[c] != 0) begin
                  g = 1; m_run[c] = 0;                    // R5
               end
            end
            m_s1[c] = m_s0[c];
            m_s0[c] = rv[c];
         end
         if (g) m_err = 1;                                // R6 set wins
         else if (err_clr) m_err = 0;
      end
   end

   task automatic check_bit(input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'h5eed_0017);
      rst_n = 0; raw_a = 0; raw_b = 0; err_clr = 0; prescale = 8'd0;
      repeat (4) @(negedge clk);
      // R1: reset state
      check_bit(filt_a, 1'b0, "R1 filt_a in reset");
      check_bit(filt_b, 1'b0, "R1 filt_b in reset");
      check_bit(noise_err, 1'b0, "R1 noise_err in reset");
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R3: P=0 step on A, visible after the fifth edge
      raw_a = 1;
      repeat (4) @(negedge clk);
      check_bit(filt_a, 1'b0, "R3 filt_a before fifth edge");
      @(negedge clk);
      check_bit(filt_a, 1'b1, "R3 filt_a after fifth edge");
      // R7: B untouched, no flag
      check_bit(filt_b, 1'b0, "R7 filt_b unaffected by A");
      check_bit(noise_err, 1'b0, "R5 no flag on clean step");

      // R4/R5: one-clock spike on B is dropped and flagged
      raw_b = 1;
      @(negedge clk); raw_b = 0;
      repeat (6) @(negedge clk);
      check_bit(filt_b, 1'b0, "R4 spike on B rejected");
      check_bit(noise_err, 1'b1, "R5 flag after spike");
      check_bit(filt_a, 1'b1, "R7 filt_a unaffected by B");

      // R6: sticky, then cleared
      repeat (20) @(negedge clk);
      check_bit(noise_err, 1'b1, "R6 flag holds while quiet");
      err_clr = 1;
      @(negedge clk); err_clr = 0;
      check_bit(noise_err, 1'b0, "R6 flag cleared by err_clr");

      // R6: clear at the glitch edge loses (glitch detected at 4th edge)
      raw_b = 1;
      @(negedge clk); raw_b = 0;
      @(negedge clk); @(negedge clk);
      err_clr = 1;
      @(negedge clk); err_clr = 0;
      check_bit(noise_err, 1'b1, "R6 set wins over clear");
      err_clr = 1;
      @(negedge clk); err_clr = 0;
      check_bit(noise_err, 1'b0, "R6 second clear");

      // R4 with a slow sample rate: 100-clock dip stays out
      prescale = 8'd255;
      repeat (3) @(negedge clk);
      raw_a = 0;
      repeat (100) @(negedge clk);
      raw_a = 1;
      repeat (10) @(negedge clk);
      check_bit(filt_a, 1'b1, "R4 dip shorter than one slow period");

      // Random phase against the model
      model_cmp = 1;
      for (int i = 0; i < 24000; i++) begin
         @(negedge clk);
         check_bit(filt_a, m_filt[0], (prescale != 0) ? "R2 filt_a vs model" : "R3 filt_a vs model");
         check_bit(filt_b, m_filt[1], "R7 filt_b vs model");
         check_bit(noise_err, m_err, "R5 R6 noise_err vs model");
         if (i % 600 == 0) begin
            case ($urandom % 6)
               0: prescale = 8'd0;
               1: prescale = 8'd1;
               2: prescale = 8'd2;
               3: prescale = 8'd3;
               4: prescale = 8'd6;
               default: prescale = 8'd9;
            endcase
         end
         if ((i / 1500) % 2 == 1) begin
            if ($urandom % 3 == 0) raw_a = ~raw_a;
            if ($urandom % 3 == 0) raw_b = ~raw_b;
         end else begin
            if ($urandom % 40 == 0) raw_a = ~raw_a;
            if ($urandom % 40 == 0) raw_b = ~raw_b;
         end
         err_clr = ($urandom % 37 == 0);
      end
      finish_run();
   end

endmodule